// File: doc/BRIEF.md
# Floating-Point Status, Exception and Compare-Code Unit

This block holds the floating-point status register of a processor core. An external FP datapath hands it one result per cycle. An arithmetic result carries five IEEE exception flags. A compare result carries a two-bit relation and a choice of one of four condition-code fields. The block folds each result into the register. The current-exception field always reflects the most recent arithmetic operation. The accrued field collects flags that did not trap. A trap request goes out whenever an exception is enabled in the trap-enable mask.

Compares behave differently from arithmetic operations. The relation code is written into the selected condition-code field, and the other three fields are left as they were. An unordered result is treated as an invalid operation in two cases: when the invalid trap is enabled, or when the compare is the signalling kind. In either case it traps. Otherwise it only sets the accrued invalid bit.

Software can read the whole register at any time and can overwrite it with a single-cycle write. A write in the same cycle as a datapath result wins, and that result is dropped.

Top module: `fpStatusUnit`

## Requirements
- R1: After reset the register reads all zeros and `trapReq` is low.
- R2: An arithmetic operation (`opValid`=1, `opIsCmp`=0) loads its flags into the current-exception field, register bits [4:0]. The flag bit order is invalid=4, overflow=3, underflow=2, divide-by-zero=1, inexact=0.
- R3: If an arithmetic operation's flags ANDed with the trap-enable mask (bits [27:23], same bit order) are nonzero, then in the cycle after the operation `trapReq` is high for one cycle and the trap-type field (bits [16:14]) holds 1 (IEEE exception). The accrued field is not changed.
- R4: An arithmetic operation that does not trap ORs its flags into the accrued field, bits [9:5], and leaves the trap-type field unchanged.
- R5: A compare writes its relation code (equal=0, less=1, greater=2, unordered=3) into the condition-code field chosen by `cmpSel`. The fields are: 0 at bits [11:10], 1 at [33:32], 2 at [35:34], 3 at [37:36]. The other condition-code fields are left unchanged.
- R6: An unordered compare traps when trap-enable bit 27 (invalid) is set or `cmpSignal` is high. It ORs the invalid bit (bit 4) into the current-exception field, sets the trap-type field to 1, and raises a one-cycle `trapReq`.
- R7: An unordered compare that does not trap sets accrued bit 9 and leaves `trapReq` low and the current-exception field unchanged.
- R8: A software write (`wrEn`=1) loads `wrData` into the whole register and takes priority over a datapath result in the same cycle. That result is dropped and raises no trap.
- R9: With neither `opValid` nor `wrEn` asserted, the register holds its value and `trapReq` stays low.
- R10: An ordered compare (equal, less, greater) changes no exception bits and never traps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | A datapath result is presented this cycle |
| opIsCmp | input | 1 | 1: result is a compare, 0: arithmetic flags |
| opFlags | input | 5 | IEEE flags of an arithmetic result |
| cmpRel | input | 2 | Compare relation code |
| cmpSel | input | 2 | Target condition-code field index |
| cmpSignal | input | 1 | Compare is the signalling variant |
| wrEn | input | 1 | Software write strobe |
| wrData | input | 38 | Software write value |
| rdData | output | 38 | Current register contents |
| trapReq | output | 1 | One-cycle trap request |

## Verification
The bench targets several corner cases. The first is an unordered compare in four variants: with and without the invalid enable, and with and without the signalling flag. A design that mixes these up would trap on a quiet compare or would only accrue on a signalling one. The second is an arithmetic operation whose flags overlap the mask in only one bit. A design that accrues on a trap, or that tests the mask at the wrong offset, shows corrupted bits [9:5] or a missing pulse. The third is a compare into fields 1 to 3. A wrong offset table, or a failure to clear the field first, leaves stale or misplaced bits. The last is a software write in the same cycle as a trapping operation. A design that lets the operation through shows a spurious `trapReq` or modified fields.

// File: rtl/fpStatusPkg.sv
package fpStatusPkg;
  localparam int REG_W    = 38;
  localparam int FLAG_W   = 5;
  localparam int CC_W     = 2;
  localparam int NUM_CC   = 4;
  localparam int SEL_W    = $clog2(NUM_CC);
  localparam int TT_W     = 3;
  localparam int CEXC_LO  = 0;
  localparam int AEXC_LO  = CEXC_LO + FLAG_W;
  localparam int CC0_LO   = 10;
  localparam int TT_LO    = 14;
  localparam int TEM_LO   = 23;
  localparam int CCX_BASE = 30;
  localparam int NV_BIT   = FLAG_W - 1;
  localparam logic [TT_W-1:0] TT_IEEE = TT_W'(1);
  localparam logic [CC_W-1:0] REL_UNORD = 2'd3;

  function automatic int ccOffset(input int idx);
    return (idx == 0) ? CC0_LO : CCX_BASE + CC_W * idx;
  endfunction

  typedef struct packed {
    logic             load;
    logic             ldCexc;
    logic             orAexc;
    logic             orCexcNv;
    logic             orAexcNv;
    logic             setTt;
    logic             ldCc;
    logic [SEL_W-1:0] ccSel;
  } fsrStrobe_t;
endpackage

// File: rtl/fpStatusCtrl.sv
module fpStatusCtrl
  import fpStatusPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic              opIsCmp,
  input  logic [FLAG_W-1:0] opFlags,
  input  logic [CC_W-1:0]   cmpRel,
  input  logic [SEL_W-1:0]  cmpSel,
  input  logic              cmpSignal,
  input  logic              wrEn,
  input  logic [FLAG_W-1:0] temQ,
  output fsrStrobe_t        strobe,
  output logic              trapReq
);
  logic arithOp, cmpOp, unordered, arithTrap, cmpTrap, trapFire;

  always_comb begin
    arithOp   = opValid && !opIsCmp && !wrEn;
    cmpOp     = opValid && opIsCmp && !wrEn;
    unordered = (cmpRel == REL_UNORD);
    arithTrap = arithOp && ((opFlags & temQ) != '0);
    cmpTrap   = cmpOp && unordered && (temQ[NV_BIT] || cmpSignal);
    trapFire  = arithTrap || cmpTrap;

    strobe.load     = wrEn;
    strobe.ldCexc   = arithOp;
    strobe.orAexc   = arithOp && !arithTrap;
    strobe.orCexcNv = cmpTrap;
    strobe.orAexcNv = cmpOp && unordered && !cmpTrap;
    strobe.setTt    = trapFire;
    strobe.ldCc     = cmpOp;
    strobe.ccSel    = cmpSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) trapReq <= 1'b0;
    else       trapReq <= trapFire;
  end
endmodule

// File: rtl/fpStatusData.sv
module fpStatusData
  import fpStatusPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  fsrStrobe_t        strobe,
  input  logic [FLAG_W-1:0] opFlags,
  input  logic [CC_W-1:0]   cmpRel,
  input  logic [REG_W-1:0]  wrData,
  output logic [FLAG_W-1:0] temQ,
  output logic [REG_W-1:0]  fsrQ
);
  logic [REG_W-1:0] fsrNext;
  logic [REG_W-1:0] ccMerged [NUM_CC];

  // One candidate value per condition-code field; the selector picks one.
  for (genvar g = 0; g < NUM_CC; g++) begin : gCcField
    localparam int LO = ccOffset(g);
    always_comb begin
      ccMerged[g] = fsrQ;
      ccMerged[g][LO +: CC_W] = cmpRel;
    end
  end

  always_comb begin
    fsrNext = fsrQ;
    if (strobe.ldCc) fsrNext = ccMerged[strobe.ccSel];
    if (strobe.ldCexc) fsrNext[CEXC_LO +: FLAG_W] = opFlags;
    if (strobe.orAexc) fsrNext[AEXC_LO +: FLAG_W] = fsrQ[AEXC_LO +: FLAG_W] | opFlags;
    if (strobe.orCexcNv) fsrNext[CEXC_LO + NV_BIT] = 1'b1;
    if (strobe.orAexcNv) fsrNext[AEXC_LO + NV_BIT] = 1'b1;
    if (strobe.setTt) fsrNext[TT_LO +: TT_W] = TT_IEEE;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            fsrQ <= '0;
    else if (strobe.load) fsrQ <= wrData;
    else                  fsrQ <= fsrNext;
  end

  assign temQ = fsrQ[TEM_LO +: FLAG_W];
endmodule

// File: rtl/fpStatusUnit.sv
module fpStatusUnit
  import fpStatusPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic              opIsCmp,
  input  logic [FLAG_W-1:0] opFlags,
  input  logic [CC_W-1:0]   cmpRel,
  input  logic [SEL_W-1:0]  cmpSel,
  input  logic              cmpSignal,
  input  logic              wrEn,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  output logic              trapReq
);
  fsrStrobe_t        strobe;
  logic [FLAG_W-1:0] temQ;

  fpStatusCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opIsCmp(opIsCmp),
    .opFlags(opFlags), .cmpRel(cmpRel), .cmpSel(cmpSel),
    .cmpSignal(cmpSignal), .wrEn(wrEn), .temQ(temQ),
    .strobe(strobe), .trapReq(trapReq)
  );

  fpStatusData data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opFlags(opFlags),
    .cmpRel(cmpRel), .wrData(wrData), .temQ(temQ), .fsrQ(rdData)
  );
endmodule

// File: rtl/fpStatusChecker.sv
module fpStatusChecker
  import fpStatusPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic              opIsCmp,
  input logic [FLAG_W-1:0] opFlags,
  input logic [CC_W-1:0]   cmpRel,
  input logic [SEL_W-1:0]  cmpSel,
  input logic              wrEn,
  input logic [REG_W-1:0]  wrData,
  input logic [REG_W-1:0]  rdData,
  input logic              trapReq
);
  function automatic logic [CC_W-1:0] ccField(input logic [REG_W-1:0] r,
                                               input logic [SEL_W-1:0] s);
    logic [CC_W-1:0] v;
    v = '0;
    for (int i = 0; i < NUM_CC; i++)
      if (s == SEL_W'(i)) v = r[ccOffset(i) +: CC_W];
    return v;
  endfunction

  logic pastRst;
  always_ff @(posedge clk) pastRst <= rstN;

  // R8: a write lands whole
  assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> rdData == $past(wrData));

  // R8, R9: a trap only follows an accepted operation
  assert_trap_needs_op_R9: assert property (@(posedge clk) disable iff (!rstN || !pastRst)
    trapReq |-> $past(opValid && !wrEn));

  // R3: trap leaves IEEE trap type
  assert_trap_type_R3: assert property (@(posedge clk) disable iff (!rstN || !pastRst)
    trapReq |-> rdData[TT_LO +: TT_W] == TT_IEEE);

  // R5: compare lands in the chosen field
  assert_cc_written_R5: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opIsCmp && !wrEn) |=> ccField(rdData, $past(cmpSel)) == $past(cmpRel));

  // R2: arithmetic op loads current-exception field
  assert_cexc_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !opIsCmp && !wrEn) |=> rdData[CEXC_LO +: FLAG_W] == $past(opFlags));

  // R9: idle holds the register
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rstN || !pastRst)
    (!$past(opValid) && !$past(wrEn)) |-> ($stable(rdData) && !trapReq));
endmodule

bind fpStatusUnit fpStatusChecker chk_i (
  .clk(clk), .rstN(rstN), .opValid(opValid), .opIsCmp(opIsCmp),
  .opFlags(opFlags), .cmpRel(cmpRel), .cmpSel(cmpSel), .wrEn(wrEn),
  .wrData(wrData), .rdData(rdData), .trapReq(trapReq)
);

// File: tb/fpStatusUnit_tb.sv
`timescale 1ns/1ps
module fpStatusUnit_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        opValid, opIsCmp, cmpSignal, wrEn;
  logic [4:0]  opFlags;
  logic [1:0]  cmpRel, cmpSel;
  logic [37:0] wrData;
  logic [37:0] rdData;
  logic        trapReq;

  int checks = 0;
  int fails  = 0;
  logic [37:0] expReg;
  logic        expTrap;
  string       tag;

  always #2.5 clk = ~clk;

  fpStatusUnit dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opIsCmp(opIsCmp),
    .opFlags(opFlags), .cmpRel(cmpRel), .cmpSel(cmpSel),
    .cmpSignal(cmpSignal), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .trapReq(trapReq)
  );

  function automatic int ccLo(input int s);
    return (s == 0) ? 10 : 30 + 2 * s;
  endfunction

  // Reference model built from the requirement text; returns {trap, next}.
  function automatic logic [38:0] model(input logic [37:0] r, input logic v,
      input logic c, input logic [4:0] f, input logic [1:0] rel,
      input logic [1:0] sel, input logic sig, input logic w,
      input logic [37:0] wd, output string t);
    logic [37:0] n;
    logic tr;
    n = r; tr = 1'b0; t = "R9";
    if (w) begin n = wd; t = "R8"; end
    else if (v && !c) begin
      n[4:0] = f;
      if ((f & r[27:23]) != 0) begin tr = 1'b1; n[16:14] = 3'd1; t = "R3"; end
      else begin n[9:5] = r[9:5] | f; t = "R4"; end
    end else if (v && c) begin
      n[ccLo(sel) +: 2] = rel;
      t = "R5";
      if (rel == 2'd3) begin
        if (r[27] || sig) begin tr = 1'b1; n[4] = 1'b1; n[16:14] = 3'd1; t = "R6"; end
        else begin n[9] = 1'b1; t = "R7"; end
      end else t = "R10";
    end
    return {tr, n};
  endfunction

  task automatic checkNow(input string t);
    checks++;
    if (rdData !== expReg) begin
      fails++;
      $display("FAIL %s rdData actual=%h expected=%h", t, rdData, expReg);
    end
    checks++;
    if (trapReq !== expTrap) begin
      fails++;
      $display("FAIL %s trapReq actual=%b expected=%b", t, trapReq, expTrap);
    end
  endtask

  task automatic step(input logic v, input logic c, input logic [4:0] f,
      input logic [1:0] rel, input logic [1:0] sel, input logic sig,
      input logic w, input logic [37:0] wd);
    logic [38:0] res;
    string t;
    opValid = v; opIsCmp = c; opFlags = f; cmpRel = rel; cmpSel = sel;
    cmpSignal = sig; wrEn = w; wrData = wd;
    res = model(expReg, v, c, f, rel, sel, sig, w, wd, t);
    @(negedge clk);
    {expTrap, expReg} = res;
    checkNow(t);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rstN = 1'b0; opValid = 0; opIsCmp = 0; opFlags = 0; cmpRel = 0;
    cmpSel = 0; cmpSignal = 0; wrEn = 0; wrData = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    expReg = '0; expTrap = 1'b0;
    checkNow("R1");

    // R2/R4: masked flags accrue
    step(1, 0, 5'b10101, 0, 0, 0, 0, '0);
    // R5: compare into each field, R10 ordered no exceptions
    for (int s = 0; s < 4; s++) step(1, 1, 0, 2'(s % 3), 2'(s), 0, 0, '0);
    // R7: quiet unordered accrues
    step(1, 1, 0, 2'd3, 2'd2, 0, 0, '0);
    // R6: signalling unordered traps
    step(1, 1, 0, 2'd3, 2'd1, 1, 0, '0);
    // R8: clear, then enable only overflow
    step(0, 0, 0, 0, 0, 0, 1, 38'h1 << 26);
    // R3: one-bit overlap traps, accrued untouched
    step(1, 0, 5'b01001, 0, 0, 0, 0, '0);
    step(0, 0, 0, 0, 0, 0, 0, '0);
    // R6: quiet unordered with invalid enabled
    step(0, 0, 0, 0, 0, 0, 1, 38'h1 << 27);
    step(1, 1, 0, 2'd3, 2'd3, 0, 0, '0);
    // R8: write beats a trapping op
    step(1, 0, 5'b10000, 0, 0, 0, 1, 38'h0_0000_00aa);

    for (int i = 0; i < 3000; i++) begin
      logic w, v;
      logic [37:0] wd;
      w  = ($urandom % 10) == 0;
      v  = ($urandom % 4) != 0;
      wd = {6'($urandom), 32'($urandom)};
      step(v, 1'($urandom), 5'($urandom), 2'($urandom), 2'($urandom),
           1'($urandom), w, wd);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule